// File: doc/BRIEF.md
# Configurable Watchdog with Relay Drive

This block is a supervision timer for a board controller. Software programs it through a 16-bit control register and proves it is alive by reading that register. The register read is the tag: it restarts the count. If no tag arrives within the selected interval while the watchdog is armed, the block enters a timed-out state. That state persists until it is cleared, and it drives a relay control line.

The block counts a slow base tick, one pulse every 1/8 s, supplied from outside. A three-bit field selects one of eight intervals. The interval doubles at each step, from 0.125 s up to 16 s. Two board jumper inputs qualify the register settings. One is XORed with the software arm bit, so a fitted jumper can arm the watchdog from power-up. The other is XORed with the software polarity bit, which lets the relay line be active either on a fault or while healthy.

Top module: `wdg_relay_top`

## Requirements
- R1: After synchronous reset, all control bits read as zero and the block is not timed out. With both jumper inputs low, `relay_ctl_o` is 0.
- R2: Control bits [2:0] hold an interval code `s`. The interval is 2^(7-s) ticks: code 0 gives 128 ticks (16 s) and code 7 gives 1 tick (0.125 s). While armed, the block times out on the tick that completes that count after a restart. The tick before it does not time it out.
- R3: A one-cycle pulse on `rd_en_i` (the tag) restarts the count. After a tag, a full interval of ticks is again needed to time out.
- R4: A tag clears the timed-out state.
- R5: The watchdog is armed only when control bit 3 XOR `jmp_en_i` is 1. While disarmed, it never times out, and the timed-out state is cleared.
- R6: `relay_ctl_o` equals timed_out XOR control bit 4 XOR `jmp_pol_i`. With the jumper low, bit 4 = 0 makes the line active-high on timeout, and bit 4 = 1 makes it active while not timed out. A high jumper inverts this.
- R7: The timed-out state is sticky. Further ticks and control writes leave it set until a tag, a disarm or a reset.
- R8: A control write, or any change of the armed condition, restarts the count. The restart uses the newly written interval, and ticks are counted from the second clock edge after the write or change.

Ticks are taken from the first clock edge after a tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 16 | Control write data: [2:0] interval code, [3] arm, [4] polarity, others ignored |
| rd_en_i | input | 1 | Control register read strobe, acts as the tag |
| jmp_en_i | input | 1 | Arm jumper level, XORed with bit 3 |
| jmp_pol_i | input | 1 | Polarity jumper level, XORed with bit 4 |
| tick_i | input | 1 | One-cycle pulse per 1/8 s base period |
| relay_ctl_o | output | 1 | Relay control line |

## Verification
The hardest states to reach are the one-tick boundaries at the ends of the interval table: 127 against 128 ticks at code 0, and a single tick at code 7. The same boundary is hard to reach right after a restart that comes from a rewrite or a jumper flip rather than a tag. Directed sequences walk every interval code to its N-1 and N tick. They then repeat the boundary after a tag, after a same-value rewrite, and with the jumper arming the block. Random trials draw the interval code, the polarity bit, the polarity jumper, the arm source and a tick count that straddles N, and predict the line from the requirement formula.

// File: rtl/wdg_relay_pkg.sv
package wdg_relay_pkg;

    localparam int CFG_W   = 16;
    localparam int SEL_W   = 3;
    localparam int CNT_W   = (1 << SEL_W);
    localparam int EN_BIT  = 3;
    localparam int POL_BIT = 4;

    typedef struct packed {
        logic             pol;
        logic             arm;
        logic [SEL_W-1:0] sel;
    } wdg_cfg_t;

    localparam int CFG_USED = $bits(wdg_cfg_t);

    // Interval length in base ticks: 2^((2^SEL_W - 1) - sel), which is 1 << ~sel.
    function automatic logic [CNT_W-1:0] ticks_for_sel(input logic [SEL_W-1:0] sel);
        logic [SEL_W-1:0] sh;
        sh = ~sel;
        return CNT_W'(1) << sh;
    endfunction

endpackage

// File: rtl/wdg_cfg_reg.sv
module wdg_cfg_reg
    import wdg_relay_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output wdg_cfg_t         cfg_q,
    output logic             upd_q
);

    logic unused_hi;
    assign unused_hi = ^wr_data[CFG_W-1:CFG_USED];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            upd_q <= 1'b0;
        end else begin
            upd_q <= wr_en;
            if (wr_en) begin
                cfg_q.sel <= wr_data[SEL_W-1:0];
                cfg_q.arm <= wr_data[EN_BIT];
                cfg_q.pol <= wr_data[POL_BIT];
            end
        end
    end

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_relay_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_eff,
    input  logic [SEL_W-1:0] sel,
    input  logic             reload_req,
    input  logic             tag,
    input  logic             tick,
    output logic             timed_out
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_val;
    logic             en_q;
    logic             en_changed;

    assign reload_val = ticks_for_sel(sel);
    assign en_changed = (en_eff != en_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= ticks_for_sel('0);
            timed_out <= 1'b0;
            en_q      <= 1'b0;
        end else begin
            en_q <= en_eff;
            if (!en_eff) begin
                cnt_q     <= reload_val;
                timed_out <= 1'b0;
            end else if (tag) begin
                cnt_q     <= reload_val;
                timed_out <= 1'b0;
            end else if (reload_req || en_changed) begin
                cnt_q <= reload_val;
            end else if (tick && !timed_out) begin
                if (cnt_q <= CNT_W'(1)) begin
                    cnt_q     <= '0;
                    timed_out <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wdg_relay_drive.sv
module wdg_relay_drive
    import wdg_relay_pkg::*;
(
    input  wdg_cfg_t cfg,
    input  logic     jmp_en,
    input  logic     jmp_pol,
    input  logic     timed_out,
    output logic     en_eff,
    output logic     relay_ctl
);

    logic pol_eff;

    assign en_eff    = cfg.arm ^ jmp_en;
    assign pol_eff   = cfg.pol ^ jmp_pol;
    assign relay_ctl = timed_out ^ pol_eff;

endmodule

// File: rtl/wdg_relay_top.sv
module wdg_relay_top
    import wdg_relay_pkg::*;
#(
    parameter int DATA_W = CFG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              jmp_en_i,
    input  logic              jmp_pol_i,
    input  logic              tick_i,
    output logic              relay_ctl_o
);

    wdg_cfg_t cfg;
    logic     cfg_upd;
    logic     en_eff;
    logic     timed_out;

    wdg_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_data (CFG_W'(wr_data_i)),
        .cfg_q   (cfg),
        .upd_q   (cfg_upd)
    );

    wdg_countdown u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en_eff     (en_eff),
        .sel        (cfg.sel),
        .reload_req (cfg_upd),
        .tag        (rd_en_i),
        .tick       (tick_i),
        .timed_out  (timed_out)
    );

    wdg_relay_drive u_drv (
        .cfg       (cfg),
        .jmp_en    (jmp_en_i),
        .jmp_pol   (jmp_pol_i),
        .timed_out (timed_out),
        .en_eff    (en_eff),
        .relay_ctl (relay_ctl_o)
    );

endmodule

// File: rtl/wdg_relay_chk.sv
module wdg_relay_chk (
    input logic clk,
    input logic rst,
    input logic rd_en,
    input logic tick,
    input logic en_eff,
    input logic timed_out
);

    // R2
    tmo_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timed_out) |-> $past(tick));

    // R4
    tag_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !timed_out);

    // R5
    disarm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !en_eff |=> !timed_out);

    // R7
    sticky_tmo_chk: assert property (@(posedge clk) disable iff (rst)
        (timed_out && en_eff && !rd_en) |=> timed_out);

    // R8
    arm_change_no_tmo_chk: assert property (@(posedge clk) disable iff (rst)
        (en_eff != $past(en_eff)) |=> !$rose(timed_out));

endmodule

bind wdg_relay_top wdg_relay_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en_i),
    .tick      (tick_i),
    .en_eff    (en_eff),
    .timed_out (timed_out)
);

// File: tb/wdg_relay_top_test.sv
`timescale 1ns/1ps
module wdg_relay_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        rd_en;
    logic        jmp_en;
    logic        jmp_pol;
    logic        tick;
    logic        relay;

    int checks   = 0;
    int failures = 0;
    bit cur_pol  = 1'b0;

    always #2.5 clk = ~clk;

    wdg_relay_top uut (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .rd_en_i     (rd_en),
        .jmp_en_i    (jmp_en),
        .jmp_pol_i   (jmp_pol),
        .tick_i      (tick),
        .relay_ctl_o (relay)
    );

    function automatic int ticks_of(input int s);
        return 128 >> s;
    endfunction

    function automatic logic exp_line(input logic tmo);
        return tmo ^ cur_pol ^ jmp_pol;
    endfunction

    task automatic chk(input string req, input logic tmo_exp);
        logic e;
        e = exp_line(tmo_exp);
        checks++;
        if (relay !== e) begin
            failures++;
            $display("FAIL %s: relay_ctl_o=%0b expected=%0b", req, relay, e);
        end
    endtask

    task automatic cfg_write(input int s, input bit arm, input bit pol);
        wr_data = 16'hFFE0 | 16'(s) | (16'(arm) << 3) | (16'(pol) << 4);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        cur_pol = pol;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic tag();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        jmp_en = 1'b0; jmp_pol = 1'b0; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", 1'b0);

        // R2 every interval code, boundary N-1 / N
        for (int s = 0; s < 8; s++) begin
            cfg_write(s, 1'b1, 1'b0);
            tag();
            ticks(ticks_of(s) - 1);
            chk("R2", 1'b0);
            ticks(1);
            chk("R2", 1'b1);
        end

        // R7 sticky across ticks and a control write; R4 tag clears
        ticks(5);
        chk("R7", 1'b1);
        cfg_write(4, 1'b1, 1'b0);
        chk("R7", 1'b1);
        tag();
        chk("R4", 1'b0);

        // R3 tag restarts the count
        ticks(7);
        tag();
        ticks(7);
        chk("R3", 1'b0);
        ticks(1);
        chk("R3", 1'b1);

        // R8 rewrite restarts with the new interval
        cfg_write(3, 1'b1, 1'b0);
        tag();
        ticks(15);
        cfg_write(3, 1'b1, 1'b0);
        ticks(15);
        chk("R8", 1'b0);
        ticks(1);
        chk("R8", 1'b1);

        // R5 disarm clears and blocks timeout
        cfg_write(7, 1'b0, 1'b0);
        chk("R5", 1'b0);
        ticks(200);
        chk("R5", 1'b0);

        // R5 jumper arms with bit 3 low, then bit 3 high disarms
        jmp_en = 1'b1;
        @(negedge clk); @(negedge clk);
        ticks(1);
        chk("R5", 1'b1);
        cfg_write(7, 1'b1, 1'b0);
        ticks(3);
        chk("R5", 1'b0);
        // R8 jumper flip restarts the count
        cfg_write(2, 1'b0, 1'b0);
        ticks(31);
        jmp_en = 1'b0;
        @(negedge clk);
        jmp_en = 1'b1;
        @(negedge clk); @(negedge clk);
        ticks(31);
        chk("R8", 1'b0);
        ticks(1);
        chk("R8", 1'b1);
        jmp_en = 1'b0;

        // R6 polarity combinations
        for (int p = 0; p < 4; p++) begin
            jmp_pol = p[1];
            cfg_write(6, 1'b1, p[0]);
            tag();
            chk("R6", 1'b0);
            ticks(2);
            chk("R6", 1'b1);
        end

        // Random trials around the boundary
        for (int t = 0; t < 30; t++) begin
            int  s;
            int  n;
            int  k;
            bit  viajmp;
            s       = int'($urandom % 8);
            n       = ticks_of(s);
            k       = (n > 4) ? (n - 2 + int'($urandom % 5)) : int'($urandom % (n + 3));
            viajmp  = bit'($urandom % 2);
            jmp_pol = logic'($urandom % 2);
            jmp_en  = viajmp;
            cfg_write(s, !viajmp, bit'($urandom % 2));
            tag();
            ticks(k);
            chk("R2", k >= n);
            chk("R6", k >= n);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule